// File: doc/BRIEF.md
# Transmit Descriptor Ring with Overflow Hold Queue

This block sits between packet switching logic and a media transmitter. The switching logic hands it outgoing packets as buffer handles, each with a length and a pool identifier. The block keeps these in a small circular set of transmit descriptors, and the transmitter drains that set one descriptor at a time. An overflow hold queue stands in front of the ring. Once any packet is waiting there, every later packet also waits there, so transmission order always equals acceptance order. When the hold queue is full, new packets are dropped and counted.

The transmitter always sees the oldest ready descriptor and signals when it has finished with it. For each finished descriptor, the block produces a one-cycle transmit interrupt and a return strobe that carries the handle and pool identifier back to the buffer allocator. On the same clock edge, the oldest held packet moves into the freed ring slot. If an enqueue and a completion occur in the same cycle, the completion is handled first.

Top module: `txr_ring_hold`

## Requirements
- R1: After reset, desc_valid, tx_irq and ret_valid are 0, and tx_count and drop_count are 0.
- R2: While the hold queue is empty and the ring has a free descriptor, an accepted packet is linked into the ring at the clock edge that samples enq_valid. tx_count then rises by one.
- R3: The ring holds RING_DEPTH descriptors (4 by default). A packet that arrives while the hold queue is empty and the ring is full is placed in the hold queue.
- R4: While the hold queue holds any packet, a new packet goes to the back of the hold queue, even in a cycle where a ring slot frees. Packets are therefore presented to the transmitter in acceptance order.
- R5: A packet that arrives when the hold queue holds HOLD_DEPTH packets and none leaves it in that cycle is discarded. drop_count then increments by one, and ring and hold contents are unchanged by it.
- R6: tx_done while desc_valid is 1 retires the presented descriptor. In the next cycle, tx_irq and ret_valid are both 1 for exactly one cycle, with ret_handle and ret_pool equal to the retired descriptor's handle and pool.
- R7: At the edge that retires a descriptor, the oldest held packet, if any, is moved into the ring, so tx_count stays at RING_DEPTH while packets remain held.
- R8: When enqueue and completion coincide, the completion is processed first. The freed slot goes to the oldest held packet, or to the new packet when nothing is held.
- R9: tx_done while the ring is empty is ignored: no interrupt, no return, and no change to any count.
- R10: desc_handle, desc_pool and desc_len always show the oldest descriptor in the ring whenever desc_valid is 1.
- R11: tx_count equals the number of descriptors awaiting transmission and never exceeds RING_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Packet offered for transmission this cycle |
| enq_handle | input | HANDLE_W | Buffer handle of offered packet |
| enq_pool | input | POOL_W | Pool the buffer belongs to |
| enq_len | input | LEN_W | Packet length in bytes |
| tx_done | input | 1 | Transmitter finished the presented descriptor |
| desc_valid | output | 1 | A descriptor is ready for the transmitter |
| desc_handle | output | HANDLE_W | Handle of oldest ready descriptor |
| desc_pool | output | POOL_W | Pool of oldest ready descriptor |
| desc_len | output | LEN_W | Length of oldest ready descriptor |
| tx_irq | output | 1 | One-cycle transmit interrupt |
| ret_valid | output | 1 | Freed buffer returned this cycle |
| ret_handle | output | HANDLE_W | Returned buffer handle |
| ret_pool | output | POOL_W | Pool receiving the returned buffer |
| tx_count | output | $clog2(RING_DEPTH+1) | Descriptors awaiting transmission |
| drop_count | output | DROP_W | Discarded packets, wrapping |

## Verification
A corrupted read or write pointer in the ring shows at the ports on the very next cycle: desc_handle then names a packet other than the oldest outstanding one, and the following return strobe carries that wrong handle. A hold-queue count that is off by one has a slower effect. It shows either as a premature drop_count step or as a packet that bypasses the held ones, and it appears only once the ring has filled and the hold queue has been exercised near its limit. For that reason the stimulus deliberately saturates both queues, then drains them, and finally interleaves enqueues with completions in the same cycle.

// File: rtl/txr_pkg.sv
// Shared widths and descriptor type for the transmit ring block.
// Assumes handles, pools and lengths are fixed-width opaque values.
package txr_pkg;
    parameter int HANDLE_W = 16;
    parameter int POOL_W   = 2;
    parameter int LEN_W    = 11;

    typedef struct packed {
        logic [HANDLE_W-1:0] handle;
        logic [POOL_W-1:0]   pool;
        logic [LEN_W-1:0]    len;
    } txr_desc_t;

    localparam int DESC_W = $bits(txr_desc_t);
endpackage

// File: rtl/txr_fifo.sv
// Circular first-in first-out store, used for both the descriptor ring
// and the hold queue. Push and pop may coincide, even when full.
// Assumes the caller never pushes into a full store without popping.
module txr_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [WIDTH-1:0]              push_data,
    input  logic                          pop,
    output logic [WIDTH-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    cnt;
    logic             do_pop, do_push;

    assign do_pop  = pop & (cnt != '0);
    assign do_push = push & ((cnt != FULL) | do_pop);
    assign head    = mem[rd_ptr];
    assign count   = cnt;

    // Store pushed entries at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    p_push_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((cnt != FULL) || pop))
        else $error("push into full store");

    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0))
        else $error("pop from empty store");
endmodule

// File: rtl/txr_return.sv
// Registers the retired descriptor into a one-cycle interrupt and
// buffer-return strobe. Assumes fire is asserted only for a real retire.
module txr_return import txr_pkg::*; (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  txr_desc_t           retired,
    output logic                irq,
    output logic                ret_valid,
    output logic [HANDLE_W-1:0] ret_handle,
    output logic [POOL_W-1:0]   ret_pool
);
    // Capture the retiring descriptor and pulse the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            ret_valid  <= 1'b0;
            ret_handle <= '0;
            ret_pool   <= '0;
        end else begin
            irq       <= fire;
            ret_valid <= fire;
            if (fire) begin
                ret_handle <= retired.handle;
                ret_pool   <= retired.pool;
            end
        end
    end
endmodule

// File: rtl/txr_drop_ctr.sv
// Wrapping counter of discarded packets. Assumes one drop per cycle at most.
module txr_drop_ctr #(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drop,
    output logic [DROP_W-1:0] count
);
    // Count discards.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (drop) count <= count + DROP_W'(1);
    end
endmodule

// File: rtl/txr_ring_hold.sv
// Transmit descriptor ring with an in-order overflow hold queue.
// Per cycle the order is: retire the presented descriptor, refill the
// ring from the hold queue, then place the new packet (ring, hold or drop).
// Assumes tx_done refers to the descriptor presented in the same cycle.
module txr_ring_hold import txr_pkg::*; #(
    parameter int RING_DEPTH = 4,
    parameter int HOLD_DEPTH = 8,
    parameter int DROP_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              enq_valid,
    input  logic [HANDLE_W-1:0]               enq_handle,
    input  logic [POOL_W-1:0]                 enq_pool,
    input  logic [LEN_W-1:0]                  enq_len,
    input  logic                              tx_done,
    output logic                              desc_valid,
    output logic [HANDLE_W-1:0]               desc_handle,
    output logic [POOL_W-1:0]                 desc_pool,
    output logic [LEN_W-1:0]                  desc_len,
    output logic                              tx_irq,
    output logic                              ret_valid,
    output logic [HANDLE_W-1:0]               ret_handle,
    output logic [POOL_W-1:0]                 ret_pool,
    output logic [$clog2(RING_DEPTH+1)-1:0]   tx_count,
    output logic [DROP_W-1:0]                 drop_count
);
    localparam int RCW = $clog2(RING_DEPTH + 1);
    localparam int HCW = $clog2(HOLD_DEPTH + 1);
    localparam logic [RCW-1:0] RING_FULL = RCW'(RING_DEPTH);
    localparam logic [HCW-1:0] HOLD_FULL = HCW'(HOLD_DEPTH);

    txr_desc_t      enq_desc, ring_head, hold_head, ring_wdata;
    logic [RCW-1:0] ring_cnt;
    logic [HCW-1:0] hold_cnt;
    logic           retire, ring_free, refill, to_ring, to_hold, drop;

    assign enq_desc = '{handle: enq_handle, pool: enq_pool, len: enq_len};

    // Placement decision: completion first, then refill, then new packet.
    always_comb begin
        retire     = tx_done & (ring_cnt != '0);
        ring_free  = (ring_cnt != RING_FULL) | retire;
        refill     = (hold_cnt != '0) & ring_free;
        to_ring    = enq_valid & (hold_cnt == '0) & ring_free;
        to_hold    = enq_valid & ~to_ring &
                     ((hold_cnt != HOLD_FULL) | refill);
        drop       = enq_valid & ~to_ring & ~to_hold;
        ring_wdata = refill ? hold_head : enq_desc;
    end

    txr_fifo #(.DEPTH(RING_DEPTH), .WIDTH(DESC_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(refill | to_ring), .push_data(ring_wdata),
        .pop(retire), .head(ring_head), .count(ring_cnt)
    );

    txr_fifo #(.DEPTH(HOLD_DEPTH), .WIDTH(DESC_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .push(to_hold), .push_data(enq_desc),
        .pop(refill), .head(hold_head), .count(hold_cnt)
    );

    txr_return u_ret (
        .clk(clk), .rst_n(rst_n), .fire(retire), .retired(ring_head),
        .irq(tx_irq), .ret_valid(ret_valid),
        .ret_handle(ret_handle), .ret_pool(ret_pool)
    );

    txr_drop_ctr #(.DROP_W(DROP_W)) u_drop (
        .clk(clk), .rst_n(rst_n), .drop(drop), .count(drop_count)
    );

    assign desc_valid  = (ring_cnt != '0);
    assign desc_handle = ring_head.handle;
    assign desc_pool   = ring_head.pool;
    assign desc_len    = ring_head.len;
    assign tx_count    = ring_cnt;

    p_hold_needs_full_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt != '0) |-> (ring_cnt == RING_FULL))
        else $error("packet held while ring has room");

    p_irq_follows_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && desc_valid) |=> (tx_irq && ret_valid))
        else $error("completion without interrupt");

    p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(tx_done && (ring_cnt != '0)))
        else $error("interrupt without completion");

    p_drop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> $past(enq_valid && (hold_cnt == HOLD_FULL)))
        else $error("drop while hold queue had room");

    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= RING_FULL)
        else $error("ring count out of range");
endmodule

// File: tb/txr_ring_hold_bench.sv
module txr_ring_hold_bench;
    import txr_pkg::*;
    localparam int RING = 4;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0;
    logic [HANDLE_W-1:0] enq_handle = '0;
    logic [POOL_W-1:0]   enq_pool = '0;
    logic [LEN_W-1:0]    enq_len = '0;
    logic tx_done = 1'b0;
    logic desc_valid, tx_irq, ret_valid;
    logic [HANDLE_W-1:0] desc_handle, ret_handle;
    logic [POOL_W-1:0]   desc_pool, ret_pool;
    logic [LEN_W-1:0]    desc_len;
    logic [2:0]          tx_count;
    logic [15:0]         drop_count;

    always #10 clk = ~clk;

    txr_ring_hold #(.RING_DEPTH(RING), .HOLD_DEPTH(HOLD), .DROP_W(16)) u_txr_ring_hold (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_handle(enq_handle),
        .enq_pool(enq_pool), .enq_len(enq_len), .tx_done(tx_done),
        .desc_valid(desc_valid), .desc_handle(desc_handle), .desc_pool(desc_pool),
        .desc_len(desc_len), .tx_irq(tx_irq), .ret_valid(ret_valid),
        .ret_handle(ret_handle), .ret_pool(ret_pool), .tx_count(tx_count),
        .drop_count(drop_count)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state: plain queues.
    txr_desc_t m_ring[$];
    txr_desc_t m_hold[$];
    int        m_drop = 0;
    bit        m_irq = 1'b0;
    txr_desc_t m_ret;
    int        seq = 1;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "desc_valid", desc_valid, m_ring.size() > 0);
        chk("R11", "tx_count", tx_count, m_ring.size());
        if (m_ring.size() > 0) begin
            chk("R10", "desc_handle", desc_handle, m_ring[0].handle);
            chk("R10", "desc_pool", desc_pool, m_ring[0].pool);
            chk("R10", "desc_len", desc_len, m_ring[0].len);
        end
        chk("R6", "tx_irq", tx_irq, m_irq);
        chk("R6", "ret_valid", ret_valid, m_irq);
        if (m_irq) begin
            chk("R6", "ret_handle", ret_handle, m_ret.handle);
            chk("R6", "ret_pool", ret_pool, m_ret.pool);
        end
        chk("R5", "drop_count", drop_count, m_drop);
    endtask

    // Reference step: completion, then refill, then placement of new packet.
    task automatic model_step(input bit enq, input txr_desc_t d, input bit done);
        int hold_before;
        m_irq = 1'b0;
        if (done && m_ring.size() > 0) begin
            m_ret = m_ring.pop_front();
            m_irq = 1'b1;
        end
        hold_before = m_hold.size();
        if (hold_before > 0 && m_ring.size() < RING) m_ring.push_back(m_hold.pop_front());
        if (enq) begin
            if (hold_before > 0) begin
                if (m_hold.size() < HOLD) m_hold.push_back(d);
                else m_drop++;
            end else if (m_ring.size() < RING) m_ring.push_back(d);
            else m_hold.push_back(d);
        end
    endtask

    task automatic run_phase(input string tag, input int cycles, input int enq_pct, input int done_pct);
        for (int i = 0; i < cycles; i++) begin
            bit e, dn;
            txr_desc_t d;
            e  = ($urandom % 100) < enq_pct;
            dn = ($urandom % 100) < done_pct;
            d.handle = HANDLE_W'(seq * 37);
            d.pool   = POOL_W'(seq);
            d.len    = LEN_W'(seq * 7 + 60);
            seq++;
            enq_valid  = e;
            enq_handle = d.handle;
            enq_pool   = d.pool;
            enq_len    = d.len;
            tx_done    = dn;
            model_step(e, d, dn);
            @(negedge clk);
            compare(tag);
        end
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "desc_valid", desc_valid, 0);
        chk("R1", "tx_count", tx_count, 0);
        chk("R1", "tx_irq", tx_irq, 0);
        chk("R1", "ret_valid", ret_valid, 0);
        chk("R1", "drop_count", drop_count, 0);
        run_phase("R2", 3, 100, 0);    // straight into ring
        run_phase("R3", 9, 100, 0);    // ring full, hold fills
        run_phase("R5", 6, 100, 0);    // hold full, drops
        run_phase("R7", 14, 0, 100);   // completions refill ring
        run_phase("R9", 4, 0, 100);    // completions on empty ring
        run_phase("R8", 30, 100, 100); // coincident enqueue and completion
        run_phase("R4", 200, 70, 30);  // deep hold, order kept
        run_phase("R10", 300, 50, 50);
        run_phase("R11", 200, 30, 60);
        enq_valid = 1'b0;
        tx_done = 1'b0;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule